// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver

This block drives a passive LCD panel with four common electrodes and thirty-two segment electrodes using 1/3 bias multiplexing. A host writes pixel data into a sixteen-byte display memory through a simple address/data write port. Each byte covers two segments across all four commons. A three-bit control register turns the driver on, blanks the segments and picks one of two waveform types.

Scanning is paced by a one-cycle `scan_tick` pulse taken from the slow clock domain's tick generator, not by the fast system clock. Every tick advances one half of a common slot, so a full frame takes eight ticks. For every electrode the block puts out a 2-bit code, and an analog stage outside this block turns each code into a bias rail: code n selects rail Vn.

Segment data are latched at the start of each common slot, so a slot never shows a mix of old and new data. In blank mode the commons keep scanning while the segment codes stay frozen.

Top module: `lcd_mux_drv`

## Requirements
- R1: After reset every output code is 0 (V0), the control register is 0 (driver disabled) and all display bytes are 0.
- R2: A write to address F0h+k (k = 0..15) stores the byte. Bits 3..0 belong to segment 2k and bits 7..4 to segment 2k+1. Within a nibble the bit for COM3 is the most significant and the bit for COM0 the least. Writes to any other address change nothing.
- R3: A control write stores bit 0 as enable, bit 1 as blank and bit 2 as waveform type (0 = type A, 1 = type B). The new setting governs the outputs from the same clock edge that stores it.
- R4: While enable is 0, every common and segment code is 0, and the scan is held at common 0, first half slot, first frame.
- R5: With the driver enabled, each `scan_tick` advances one half slot. Each common gets two half slots, and the commons are visited in the order 0, 1, 2, 3, then back to 0.
- R6: The selected common is driven with code 3 when polarity is 0 and code 0 when polarity is 1. Every unselected common is driven with code 1 when polarity is 0 and code 2 when polarity is 1.
- R7: A segment whose bit for the selected common is 1 (ON) is driven with code 0 when polarity is 0 and code 3 when polarity is 1. An OFF segment is driven with code 2 when polarity is 0 and code 1 when polarity is 1.
- R8: In type A, polarity is 0 in the first half of each common slot and 1 in the second half.
- R9: In type B, polarity stays constant for a whole four-common frame and flips at each frame boundary. The first frame after enable has polarity 0.
- R10: Segment data are sampled from memory when a common slot begins, and on every cycle while disabled. A write made during a slot first appears when the next slot begins.
- R11: While enabled with blank set, the commons keep scanning and every segment code holds the value it had before blank was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_tick | input | 1 | One-cycle slow-clock pacing pulse, one half slot per pulse |
| ram_we | input | 1 | Display memory write strobe |
| ram_addr | input | 8 | Display memory byte address (window F0h..FFh) |
| ram_wdata | input | 8 | Display memory write data |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | Control value: bit 2 type, bit 1 blank, bit 0 enable |
| com_lvl | output | 8 | Common level codes, common c at bits 2c+1..2c |
| seg_lvl | output | 64 | Segment level codes, segment s at bits 2s+1..2s |

## Verification
The output registers are loaded from the next state, so every stimulus applied before a rising edge (a tick, a control write, or the enable falling) shows on `com_lvl` and `seg_lvl` right after that edge. The bench therefore drives at the falling edge, updates its model at the rising edge, and compares at the following falling edge. A memory write reaches the segment outputs only at the edge where a later tick opens a new slot, and the model copies the memory into its slot snapshot before it applies that cycle's write. Writes during the opening tick therefore land one slot later, as R10 requires.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
    localparam int unsigned NUM_COM = 4;

    typedef enum logic [1:0] {
        LVL_V0 = 2'd0,
        LVL_V1 = 2'd1,
        LVL_V2 = 2'd2,
        LVL_V3 = 2'd3
    } lvl_e;

    typedef struct packed {
        logic wave_b;
        logic blank;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
    parameter int unsigned NUM_SEG   = 32,
    parameter int unsigned AW        = 8,
    parameter logic [7:0]  BASE_ADDR = 8'hF0,
    parameter int unsigned CW        = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [CW-1:0]      rd_com,
    output logic [NUM_SEG-1:0] col_bits
);
    localparam int unsigned DEPTH = NUM_SEG / 2;
    localparam int unsigned IW    = $clog2(DEPTH);

    logic [DEPTH-1:0][7:0] ram_d, ram_q;
    logic [AW-1:0]         offset;
    logic                  hit;

    assign offset = wr_addr - AW'(BASE_ADDR);
    assign hit    = (offset < AW'(DEPTH));

    always_comb begin
        ram_d = ram_q;
        if (wr_en && hit) begin
            ram_d[offset[IW-1:0]] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ram_q <= '0;
        else        ram_q <= ram_d;
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_col
        localparam int unsigned BYTE = s / 2;
        localparam int unsigned NIB  = (s % 2) * 4;
        logic [3:0] nib;
        assign nib         = ram_q[BYTE][NIB+3:NIB];
        assign col_bits[s] = nib[rd_com];
    end

    // R2
    ram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit) |=> $stable(ram_q));
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq #(
    parameter int unsigned NUM_COM = 4,
    parameter int unsigned CW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          wave_b,
    output logic [CW-1:0] com_nxt,
    output logic          pol_nxt,
    output logic          slot_load
);
    typedef struct packed {
        logic          frame;
        logic [CW-1:0] com;
        logic          half;
    } scan_t;

    scan_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        slot_load = 1'b0;
        if (!run) begin
            st_d      = '0;
            slot_load = 1'b1;
        end else if (tick) begin
            if (st_q.half) begin
                st_d.half = 1'b0;
                slot_load = 1'b1;
                if (st_q.com == CW'(NUM_COM - 1)) begin
                    st_d.com   = '0;
                    st_d.frame = ~st_q.frame;
                end else begin
                    st_d.com = st_q.com + 1'b1;
                end
            end else begin
                st_d.half = 1'b1;
            end
        end
        com_nxt = st_d.com;
        pol_nxt = wave_b ? st_d.frame : st_d.half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    half_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run && tick) |-> (st_q.half != $past(st_q.half)));

    // R5
    com_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run && !tick) |-> $stable(st_q));

    // R4
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run) |-> (st_q == '0));
endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
    import lcd_drv_pkg::*;
#(
    parameter int unsigned NUM_COM = 4,
    parameter int unsigned NUM_SEG = 32,
    parameter int unsigned CW      = 2
) (
    input  logic [CW-1:0]        com_idx,
    input  logic                 pol,
    input  logic [NUM_SEG-1:0]   seg_on,
    output logic [2*NUM_COM-1:0] com_code,
    output logic [2*NUM_SEG-1:0] seg_code
);
    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
        lvl_e lvl;
        always_comb begin
            if (com_idx == CW'(c)) lvl = pol ? LVL_V0 : LVL_V3;
            else                   lvl = pol ? LVL_V2 : LVL_V1;
        end
        assign com_code[2*c +: 2] = lvl;
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        lvl_e lvl;
        always_comb begin
            if (seg_on[s]) lvl = pol ? LVL_V3 : LVL_V0;
            else           lvl = pol ? LVL_V1 : LVL_V2;
        end
        assign seg_code[2*s +: 2] = lvl;
    end
endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv
    import lcd_drv_pkg::*;
#(
    parameter int unsigned NUM_SEG   = 32,
    parameter int unsigned AW        = 8,
    parameter logic [7:0]  BASE_ADDR = 8'hF0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_tick,
    input  logic                 ram_we,
    input  logic [AW-1:0]        ram_addr,
    input  logic [7:0]           ram_wdata,
    input  logic                 ctrl_we,
    input  logic [2:0]           ctrl_wdata,
    output logic [2*NUM_COM-1:0] com_lvl,
    output logic [2*NUM_SEG-1:0] seg_lvl
);
    localparam int unsigned CW = $clog2(NUM_COM);

    typedef struct packed {
        ctrl_t                ctrl;
        logic [NUM_SEG-1:0]   snap;
        logic [2*NUM_COM-1:0] com;
        logic [2*NUM_SEG-1:0] seg;
    } top_t;

    top_t                 cur_q, nxt_d;
    ctrl_t                ctrl_d;
    logic [CW-1:0]        com_nxt;
    logic                 pol_nxt, slot_load;
    logic [NUM_SEG-1:0]   col_bits;
    logic [NUM_SEG-1:0]   snap_d;
    logic [2*NUM_COM-1:0] map_com;
    logic [2*NUM_SEG-1:0] map_seg;

    assign ctrl_d = ctrl_we ? ctrl_t'(ctrl_wdata) : cur_q.ctrl;
    assign snap_d = slot_load ? col_bits : cur_q.snap;

    lcd_disp_ram #(.NUM_SEG(NUM_SEG), .AW(AW), .BASE_ADDR(BASE_ADDR), .CW(CW)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(ram_we), .wr_addr(ram_addr),
        .wr_data(ram_wdata), .rd_com(com_nxt), .col_bits(col_bits)
    );

    lcd_scan_seq #(.NUM_COM(NUM_COM), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(ctrl_d.en), .tick(scan_tick),
        .wave_b(ctrl_d.wave_b), .com_nxt(com_nxt), .pol_nxt(pol_nxt),
        .slot_load(slot_load)
    );

    lcd_level_map #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .CW(CW)) u_map (
        .com_idx(com_nxt), .pol(pol_nxt), .seg_on(snap_d),
        .com_code(map_com), .seg_code(map_seg)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.ctrl = ctrl_d;
        nxt_d.snap = snap_d;
        if (!ctrl_d.en) begin
            nxt_d.com = '0;
            nxt_d.seg = '0;
        end else begin
            nxt_d.com = map_com;
            nxt_d.seg = ctrl_d.blank ? cur_q.seg : map_seg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign com_lvl = cur_q.com;
    assign seg_lvl = cur_q.seg;

    logic [NUM_COM-1:0] sel_vec;
    for (genvar c = 0; c < NUM_COM; c++) begin : g_sel
        assign sel_vec[c] = (cur_q.com[2*c] == cur_q.com[2*c+1]);
    end

    // R4
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.ctrl.en |-> (com_lvl == '0 && seg_lvl == '0));

    // R6
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.ctrl.en |-> ($countones(sel_vec) == 1));

    // R11
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ctrl.en && cur_q.ctrl.blank && $past(cur_q.ctrl.en && cur_q.ctrl.blank))
        |-> $stable(seg_lvl));
endmodule

// File: tb/lcd_mux_drv_tb.sv
module lcd_mux_drv_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_tick = 1'b0;
    logic        ram_we = 1'b0;
    logic [7:0]  ram_addr = '0;
    logic [7:0]  ram_wdata = '0;
    logic        ctrl_we = 1'b0;
    logic [2:0]  ctrl_wdata = '0;
    logic [7:0]  com_lvl;
    logic [63:0] seg_lvl;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0]  m_ram [16];
    logic        m_en = 0, m_blank = 0, m_typ = 0;
    logic        m_half = 0, m_frame = 0;
    int          m_com = 0;
    logic [31:0] m_snap = '0;
    logic [7:0]  m_comx = '0;
    logic [63:0] m_seg = '0;

    always #2.5 clk = ~clk;

    lcd_mux_drv u_dut (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    function automatic logic [31:0] col(int c);
        logic [31:0] r;
        for (int s = 0; s < 32; s++) r[s] = m_ram[s/2][(s%2)*4 + c];
        return r;
    endfunction

    task automatic model_update();
        logic pol;
        if (ctrl_we) {m_typ, m_blank, m_en} = ctrl_wdata;
        if (!m_en) begin
            m_half = 0; m_com = 0; m_frame = 0;
            m_snap = col(0);
        end else if (scan_tick) begin
            if (m_half) begin
                m_half = 0;
                m_com = (m_com + 1) % 4;
                if (m_com == 0) m_frame = ~m_frame;
                m_snap = col(m_com);
            end else begin
                m_half = 1;
            end
        end
        if (ram_we && ram_addr >= 8'hF0) m_ram[ram_addr - 8'hF0] = ram_wdata;
        pol = m_typ ? m_frame : m_half;
        for (int c = 0; c < 4; c++)
            m_comx[2*c +: 2] = !m_en ? 2'd0 : (c == m_com) ? (pol ? 2'd0 : 2'd3)
                                                          : (pol ? 2'd2 : 2'd1);
        if (!m_en) m_seg = '0;
        else if (!m_blank)
            for (int s = 0; s < 32; s++)
                m_seg[2*s +: 2] = m_snap[s] ? (pol ? 2'd3 : 2'd0) : (pol ? 2'd1 : 2'd2);
    endtask

    task automatic compare(string tc, string ts);
        checks++;
        if (com_lvl !== m_comx) begin
            errors++;
            $display("FAIL %s com_lvl got %h exp %h", tc, com_lvl, m_comx);
        end
        checks++;
        if (seg_lvl !== m_seg) begin
            errors++;
            $display("FAIL %s seg_lvl got %h exp %h", ts, seg_lvl, m_seg);
        end
    endtask

    task automatic step(bit tk, bit we, logic [7:0] a, logic [7:0] d,
                        bit cwe, logic [2:0] cd, string tc, string ts);
        scan_tick = tk; ram_we = we; ram_addr = a; ram_wdata = d;
        ctrl_we = cwe; ctrl_wdata = cd;
        @(posedge clk);
        #1 model_update();
        @(negedge clk);
        compare(tc, ts);
    endtask

    task automatic ticks(int n, string tc, string ts);
        for (int i = 0; i < n; i++) begin
            step(1, 0, 8'h00, 8'h00, 0, 3'd0, tc, ts);
            step(0, 0, 8'h00, 8'h00, 0, 3'd0, tc, ts);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R5 watchdog got hang exp finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed_v;
        for (int i = 0; i < 16; i++) m_ram[i] = '0;
        seed_v = $urandom(32'h5EED_1CD0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1", "R1");

        // R3: enable type A, no blank
        step(0, 0, 8'h00, 8'h00, 1, 3'b001, "R3", "R3");
        // R2: mapping and out-of-window writes ignored
        step(0, 1, 8'hF3, 8'h21, 0, 3'd0, "R2", "R2");
        step(0, 1, 8'hEF, 8'hFF, 0, 3'd0, "R2", "R2");
        step(0, 1, 8'h00, 8'hFF, 0, 3'd0, "R2", "R2");
        step(0, 1, 8'hF0, 8'h8C, 0, 3'd0, "R2", "R2");
        step(0, 1, 8'hFF, 8'h5A, 0, 3'd0, "R2", "R2");
        ticks(8, "R5", "R2");
        // R10: write mid-slot, then on a slot-opening tick
        step(1, 0, 8'h00, 8'h00, 0, 3'd0, "R8", "R10");
        step(0, 1, 8'hF3, 8'hFF, 0, 3'd0, "R8", "R10");
        step(0, 0, 8'h00, 8'h00, 0, 3'd0, "R8", "R10");
        step(1, 1, 8'hF4, 8'hFF, 0, 3'd0, "R8", "R10");
        ticks(6, "R6", "R10");
        // R9: type B over several frames
        step(0, 0, 8'h00, 8'h00, 1, 3'b100, "R4", "R4");
        step(0, 0, 8'h00, 8'h00, 1, 3'b101, "R9", "R7");
        ticks(20, "R9", "R7");
        // R11: blank while scanning
        step(0, 0, 8'h00, 8'h00, 1, 3'b111, "R11", "R11");
        step(0, 1, 8'hF0, 8'h00, 0, 3'd0, "R11", "R11");
        ticks(10, "R11", "R11");
        // R4: disable mid-scan
        step(1, 0, 8'h00, 8'h00, 1, 3'b000, "R4", "R4");
        ticks(3, "R4", "R4");

        for (int i = 0; i < 3000; i++) begin
            bit tk, we, cwe;
            logic [7:0] a, d;
            logic [2:0] cd;
            tk  = ($urandom % 3) == 0;
            we  = ($urandom % 4) == 0;
            a   = (($urandom % 8) == 0) ? 8'($urandom) : (8'hF0 | 8'($urandom % 16));
            d   = 8'($urandom);
            cwe = ($urandom % 40) == 0;
            cd  = {2'($urandom), 1'(($urandom % 6) != 0)};
            step(tk, we, a, d, cwe, cd, "R6", "R7");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule